// File: doc/BRIEF.md
# Register-Mapped Serial Port

This block is a byte-wide asynchronous serial port that software drives through six word registers. Those registers hold the last received byte, the byte to send, a status word, a control word, a baud divisor and an end-of-packet character. Software loads a byte into the transmit register to send it. The receiver places each incoming byte in a single holding register and raises a ready flag. The status word shows that flag together with the error flags.

The status word and the control word share one bit map. A control bit enables the status flag at the same bit position as an interrupt source, and the interrupt output is the OR of all enabled flags. Two kinds of read change the flags. Reading the status word clears the sticky error flags, and reading the receive register clears the ready flag. Frames are 8N1: one low start bit, eight data bits sent LSB first, and one high stop bit. Each bit lasts divisor+1 clock cycles.

Top module: `uart_regbank`

## Requirements
- R1: After reset, status reads 0x0060 (bit 5 transmitter empty and bit 6 transmit ready are set, all other bits are clear). Control and the receive register read 0, `irq` is low and `uart_txd` is high.
- R2: Only `bus_addr[2:0]` selects a register: 0 receive, 1 transmit, 2 status, 3 control, 4 divisor, 5 end-of-packet. The upper address bits are ignored, so the register map repeats every 8 words. Indices 6 and 7 read 0.
- R3: Writes to index 0 (receive) and index 2 (status) change no state. A later read of either register returns the same value as before the write.
- R4: A write to index 1 stores `bus_wdata[7:0]`, which reads back at index 1. If the transmitter is idle, the write also starts a frame on `uart_txd`: one low start bit, eight data bits LSB first, then one high stop bit. Each bit lasts divisor+1 cycles. The line idles high.
- R5: Status bits 5 and 6 are clear while a frame is being sent and are set again once the stop bit finishes. A write to index 1 while a frame is in progress does not send that byte, and it sets bit 4 (transmit overrun) and bit 8 (any error).
- R6: A received byte with a valid stop bit goes into the receive register and sets bit 7 (receive ready). Reading index 0 returns the byte and clears bit 7.
- R7: If a byte arrives while bit 7 is still set, the new byte is discarded and the held byte is kept. Bits 3 (receive overrun) and 8 are set.
- R8: If the stop bit is sampled low, the byte is still stored, and bits 1 (framing error), 7 and 8 are set. If all eight data bits are also zero, bit 2 (break) is set as well.
- R9: Read data appears on `bus_rdata` one cycle after the read request and holds the value from before the read. A status read clears bits 0–4, 8 and 10. A flag event in the same cycle as the read takes priority over the clear.
- R10: `irq` is high exactly when (status AND control) is non-zero over bits 0–8 and 10. Bit 12 (end-of-packet) never raises `irq`.
- R11: Control keeps its low 13 bits, the divisor keeps its low DIV_W bits and the end-of-packet register keeps its low 8 bits. Each reads back with those widths. Control bit 9 holds `uart_txd` low for as long as it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| bus_req | input | 1 | Register access strobe, valid for one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word index; only the low 3 bits are decoded |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read request |
| uart_rxd | input | 1 | Serial receive line |
| uart_txd | output | 1 | Serial transmit line |
| irq | output | 1 | Level interrupt |

## Verification
The bench instantiates the block with ADDR_W=4, DIV_W=8 and DIV_RST=9. A 4-bit address reaches indices 8 to 15, which exercises the aliasing of the register map (address 10 must return the status word). With an 8-bit divisor, a 16-bit write to the divisor register shows that the upper byte is dropped. The bit time is 10 cycles, so sampling at mid-bit stays well away from bit edges while frames remain short. That leaves room for back-to-back receive frames (overrun), frames with a low stop bit (framing error and break), and a second transmit write that arrives during a frame.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  // status / control bit positions (shared map)
  localparam int ST_PE   = 0;
  localparam int ST_FE   = 1;
  localparam int ST_BRK  = 2;
  localparam int ST_ROE  = 3;
  localparam int ST_TOE  = 4;
  localparam int ST_TMT  = 5;
  localparam int ST_TRDY = 6;
  localparam int ST_RRDY = 7;
  localparam int ST_ERR  = 8;
  localparam int ST_DCTS = 10;
  localparam int ST_CTS  = 11;
  localparam int ST_EOP  = 12;
  localparam int CT_TXBRK = 9;

  localparam int REG_W  = 16;
  localparam int CTRL_W = 13;
  localparam int FRAME_BITS = 10;

  localparam logic [REG_W-1:0] IRQ_MASK   = 16'h05FF;
  localparam logic [REG_W-1:0] RDCLR_MASK = 16'h051F;

  typedef enum logic [2:0] {
    SEL_RXD  = 3'd0,
    SEL_TXD  = 3'd1,
    SEL_STAT = 3'd2,
    SEL_CTRL = 3'd3,
    SEL_DIV  = 3'd4,
    SEL_EOP  = 3'd5,
    SEL_NA6  = 3'd6,
    SEL_NA7  = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_rb_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [7:0]       byte_in,
  input  logic [DIV_W-1:0] divisor,
  output logic             busy,
  output logic             line
);
  localparam int IDX_W = $clog2(FRAME_BITS);

  logic                  busy_q, busy_n;
  logic [DIV_W-1:0]      cnt_q, cnt_n;
  logic [IDX_W-1:0]      idx_q, idx_n;
  logic [FRAME_BITS-1:0] shr_q, shr_n;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    idx_n  = idx_q;
    shr_n  = shr_q;
    if (load && !busy_q) begin
      busy_n = 1'b1;
      cnt_n  = '0;
      idx_n  = '0;
      shr_n  = {1'b1, byte_in, 1'b0};
    end else if (busy_q) begin
      if (cnt_q == divisor) begin
        cnt_n = '0;
        if (idx_q == IDX_W'(FRAME_BITS - 1)) begin
          busy_n = 1'b0;
          shr_n  = '1;
        end else begin
          shr_n = {1'b1, shr_q[FRAME_BITS-1:1]};
          idx_n = idx_q + 1'b1;
        end
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      shr_q  <= '1;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      idx_q  <= idx_n;
      shr_q  <= shr_n;
    end
  end

  assign busy = busy_q;
  assign line = shr_q[0];
endmodule

// File: rtl/uart_rx_sample.sv
module uart_rx_sample
  import uart_rb_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  input  logic [DIV_W-1:0] divisor,
  output logic             done,
  output logic [7:0]       data,
  output logic             stop_bad
);
  logic [2:0]       sync_q;
  rx_state_e        st_q, st_n;
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic [2:0]       idx_q, idx_n;
  logic [7:0]       shr_q, shr_n;
  logic             done_q, done_n;
  logic             bad_q, bad_n;
  logic             line, fall;

  assign line = sync_q[1];
  assign fall = sync_q[2] & ~sync_q[1];

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    idx_n  = idx_q;
    shr_n  = shr_q;
    done_n = 1'b0;
    bad_n  = bad_q;
    unique case (st_q)
      RX_IDLE: begin
        if (fall) begin
          st_n  = RX_START;
          cnt_n = '0;
        end
      end
      RX_START: begin
        if (cnt_q == (divisor >> 1)) begin
          cnt_n = '0;
          idx_n = '0;
          st_n  = line ? RX_IDLE : RX_DATA;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      RX_DATA: begin
        if (cnt_q == divisor) begin
          cnt_n = '0;
          shr_n = {line, shr_q[7:1]};
          if (idx_q == 3'd7) st_n = RX_STOP;
          else idx_n = idx_q + 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      RX_STOP: begin
        if (cnt_q == divisor) begin
          cnt_n  = '0;
          done_n = 1'b1;
          bad_n  = ~line;
          st_n   = RX_IDLE;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      default: st_n = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      shr_q  <= '0;
      done_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], rxd};
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      idx_q  <= idx_n;
      shr_q  <= shr_n;
      done_q <= done_n;
      bad_q  <= bad_n;
    end
  end

  assign done     = done_q;
  assign data     = shr_q;
  assign stop_bad = bad_q;
endmodule

// File: rtl/uart_csr.sv
module uart_csr
  import uart_rb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned DIV_RST = 433
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              tx_busy,
  input  logic              rx_done,
  input  logic [7:0]        rx_data,
  input  logic              rx_stop_bad,
  output logic              tx_load,
  output logic [7:0]        tx_byte,
  output logic [CTRL_W-1:0] ctrl,
  output logic [DIV_W-1:0]  divisor,
  output logic [REG_W-1:0]  status,
  output logic              irq
);
  reg_sel_e          sel;
  logic              rd_en, wr_en;
  logic [REG_W-1:0]  flag_q, flag_n;
  logic [7:0]        rxb_q, rxb_n;
  logic [7:0]        txb_q, txb_n;
  logic [CTRL_W-1:0] ctrl_q, ctrl_n;
  logic [DIV_W-1:0]  div_q, div_n;
  logic [7:0]        eop_q, eop_n;
  logic [REG_W-1:0]  rdata_q, rdata_n, rd_mux;
  logic              unused_bus;

  assign sel        = reg_sel_e'(bus_addr[2:0]);
  assign rd_en      = bus_req & ~bus_wr;
  assign wr_en      = bus_req & bus_wr;
  assign unused_bus = ^{bus_addr, bus_wdata};

  // live status: sticky flags plus transmitter state
  always_comb begin
    status          = flag_q;
    status[ST_TMT]  = ~tx_busy;
    status[ST_TRDY] = ~tx_busy;
  end

  always_comb begin
    unique case (sel)
      SEL_RXD:  rd_mux = REG_W'(rxb_q);
      SEL_TXD:  rd_mux = REG_W'(txb_q);
      SEL_STAT: rd_mux = status;
      SEL_CTRL: rd_mux = REG_W'(ctrl_q);
      SEL_DIV:  rd_mux = REG_W'(div_q);
      SEL_EOP:  rd_mux = REG_W'(eop_q);
      default:  rd_mux = '0;
    endcase
  end

  always_comb begin
    flag_n  = flag_q;
    rxb_n   = rxb_q;
    txb_n   = txb_q;
    ctrl_n  = ctrl_q;
    div_n   = div_q;
    eop_n   = eop_q;
    rdata_n = rdata_q;
    // read side effects (clears first, events below override)
    if (rd_en) begin
      rdata_n = rd_mux;
      if (sel == SEL_STAT) flag_n = flag_n & ~RDCLR_MASK;
      if (sel == SEL_RXD)  flag_n[ST_RRDY] = 1'b0;
    end
    if (wr_en) begin
      unique case (sel)
        SEL_TXD: begin
          txb_n = bus_wdata[7:0];
          if (tx_busy) begin
            flag_n[ST_TOE] = 1'b1;
            flag_n[ST_ERR] = 1'b1;
          end
        end
        SEL_CTRL: ctrl_n = bus_wdata[CTRL_W-1:0];
        SEL_DIV:  div_n  = bus_wdata[DIV_W-1:0];
        SEL_EOP:  eop_n  = bus_wdata[7:0];
        default: ;
      endcase
    end
    if (rx_done) begin
      if (flag_n[ST_RRDY]) begin
        flag_n[ST_ROE] = 1'b1;
        flag_n[ST_ERR] = 1'b1;
      end else begin
        rxb_n           = rx_data;
        flag_n[ST_RRDY] = 1'b1;
        if (rx_stop_bad) begin
          flag_n[ST_FE]  = 1'b1;
          flag_n[ST_ERR] = 1'b1;
          if (rx_data == 8'h00) flag_n[ST_BRK] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= '0;
      rxb_q   <= '0;
      txb_q   <= '0;
      ctrl_q  <= '0;
      div_q   <= DIV_W'(DIV_RST);
      eop_q   <= '0;
      rdata_q <= '0;
    end else begin
      flag_q  <= flag_n;
      rxb_q   <= rxb_n;
      txb_q   <= txb_n;
      ctrl_q  <= ctrl_n;
      div_q   <= div_n;
      eop_q   <= eop_n;
      rdata_q <= rdata_n;
    end
  end

  assign tx_load   = wr_en && (sel == SEL_TXD) && !tx_busy;
  assign tx_byte   = bus_wdata[7:0];
  assign ctrl      = ctrl_q;
  assign divisor   = div_q;
  assign bus_rdata = rdata_q;
  assign irq       = |(status & REG_W'(ctrl_q) & IRQ_MASK);
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_rb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned DIV_RST = 433
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              uart_rxd,
  output logic              uart_txd,
  output logic              irq
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              tx_busy, tx_line, tx_load;
  logic [7:0]        tx_byte;
  logic              rx_done, rx_stop_bad;
  logic [7:0]        rx_data;
  logic [CTRL_W-1:0] ctrl_w;
  logic [DIV_W-1:0]  div_w;
  logic [REG_W-1:0]  status_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  uart_csr #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_csr (
    .clk(clk), .rst_n(rst_int_n),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_busy(tx_busy), .rx_done(rx_done), .rx_data(rx_data),
    .rx_stop_bad(rx_stop_bad), .tx_load(tx_load), .tx_byte(tx_byte),
    .ctrl(ctrl_w), .divisor(div_w), .status(status_w), .irq(irq)
  );

  uart_tx_shift #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_int_n), .load(tx_load), .byte_in(tx_byte),
    .divisor(div_w), .busy(tx_busy), .line(tx_line)
  );

  uart_rx_sample #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_int_n), .rxd(uart_rxd), .divisor(div_w),
    .done(rx_done), .data(rx_data), .stop_bad(rx_stop_bad)
  );

  assign uart_txd = tx_line & ~ctrl_w[CT_TXBRK];
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_wr,
  input logic [2:0]  bus_sel,
  input logic        tx_busy,
  input logic        uart_txd,
  input logic [12:0] ctrl,
  input logic [15:0] status,
  input logic        rx_done,
  input logic        irq
);
  logic rd_any, wr_any;
  assign rd_any = bus_req & ~bus_wr;
  assign wr_any = bus_req & bus_wr;

  // R4: a frame begins only after a transmit-register write
  p_tx_start_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(wr_any && bus_sel == 3'd1));

  // R4 / R11: idle line is high unless break forced
  p_idle_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !ctrl[9]) |-> uart_txd);

  // R5: write during a frame flags transmit overrun
  p_tx_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && bus_sel == 3'd1 && tx_busy) |=> (status[4] && status[8]));

  // R6: reading the receive register drops receive ready
  p_rrdy_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && bus_sel == 3'd0 && !rx_done) |=> !status[7]);

  // R7: arrival while full marks overrun and keeps ready
  p_rx_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && status[7] && !(rd_any && bus_sel == 3'd0))
      |=> (status[3] && status[8] && status[7]));

  // R9: status read clears the sticky error group
  p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && bus_sel == 3'd2 && !rx_done) |=> ((status & 16'h051F) == 16'h0000));

  // R10: no enabled source, no interrupt
  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl[10:0] & 11'h5FF) == 11'h000) |-> !irq);

  // R10: end-of-packet flag is never raised
  p_eop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !status[12]);
endmodule

bind uart_regbank uart_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_int_n), .bus_req(bus_req), .bus_wr(bus_wr),
  .bus_sel(bus_addr[2:0]), .tx_busy(tx_busy), .uart_txd(uart_txd),
  .ctrl(ctrl_w), .status(status_w), .rx_done(rx_done), .irq(irq)
);

// File: tb/sim_uart_regbank.sv
module sim_uart_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W  = 4;
  localparam int DIV_W   = 8;
  localparam int DIV_RST = 9;
  localparam int BT      = DIV_RST + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_req = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [15:0]       bus_wdata = '0;
  logic [15:0]       bus_rdata;
  logic              uart_rxd = 1'b1;
  logic              uart_txd;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;
  bit tx_mon_en = 1'b1;
  bit rd_seen = 1'b0;

  logic [15:0] rd_exp_q[$];
  string       rd_tag_q[$];
  logic [7:0]  tx_exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regbank #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .DIV_RST(DIV_RST)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .uart_rxd(uart_rxd), .uart_txd(uart_txd), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int addr, input logic [15:0] data);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b1;
    bus_addr = ADDR_W'(addr); bus_wdata = data;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  // driver: queue the expectation, then issue the read
  task automatic bus_read(input int addr, input logic [15:0] exp, input string tag);
    @(negedge clk);
    rd_exp_q.push_back(exp);
    rd_tag_q.push_back(tag);
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(addr);
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  // read monitor: data is due one cycle after the request
  always @(posedge clk) rd_seen <= bus_req & ~bus_wr;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (rd_exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected read", int'(bus_rdata), 0);
      end else begin
        logic [15:0] e;
        string t;
        e = rd_exp_q.pop_front();
        t = rd_tag_q.pop_front();
        check(bus_rdata === e, t, int'(bus_rdata), int'(e));
      end
    end
  end

  // transmit monitor: decode frames at mid-bit
  always begin
    @(negedge clk);
    if (tx_mon_en && uart_txd === 1'b0) begin
      logic [7:0] got;
      logic       stp;
      repeat (BT/2) @(negedge clk);
      check(uart_txd === 1'b0, "R4 start bit", int'(uart_txd), 0);
      for (int i = 0; i < 8; i++) begin
        repeat (BT) @(negedge clk);
        got[i] = uart_txd;
      end
      repeat (BT) @(negedge clk);
      stp = uart_txd;
      check(stp === 1'b1, "R4 stop bit", int'(stp), 1);
      if (tx_exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected frame", int'(got), 0);
      end else begin
        logic [7:0] e;
        e = tx_exp_q.pop_front();
        check(got === e, "R4 frame data", int'(got), int'(e));
      end
    end
  end

  task automatic send_rx(input logic [7:0] b, input bit stop_ok);
    logic [9:0] frame;
    frame = {stop_ok, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      uart_rxd = frame[i];
      repeat (BT - 1) @(negedge clk);
    end
    @(negedge clk);
    uart_rxd = 1'b1;
    repeat (2 * BT) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(irq === 1'b0, "R1 irq low", int'(irq), 0);
    check(uart_txd === 1'b1, "R1 txd high", int'(uart_txd), 1);
    bus_read(2, 16'h0060, "R1 status");
    bus_read(3, 16'h0000, "R1 control");
    bus_read(0, 16'h0000, "R1 rxdata");
    bus_read(4, 16'h0009, "R11 divisor reset");

    // R2 decode
    bus_read(10, 16'h0060, "R2 alias of status");
    bus_read(6, 16'h0000, "R2 index 6");
    bus_read(15, 16'h0000, "R2 index 7 alias");

    // R3 ignored writes
    bus_write(0, 16'h0055);
    bus_write(2, 16'hFFFF);
    bus_read(2, 16'h0060, "R3 status unchanged");
    bus_read(0, 16'h0000, "R3 rxdata unchanged");

    // R11 width masks
    bus_write(5, 16'h01A5);
    bus_read(5, 16'h00A5, "R11 eop mask");
    bus_write(4, 16'h0109);
    bus_read(4, 16'h0009, "R11 divisor mask");

    // R4/R5 transmit, overrun while busy
    tx_exp_q.push_back(8'h3C);
    bus_write(1, 16'h003C);
    bus_read(2, 16'h0000, "R5 busy clears ready");
    bus_write(1, 16'h0099);
    bus_read(2, 16'h0110, "R5 transmit overrun");
    bus_read(2, 16'h0000, "R9 errors cleared");
    bus_read(1, 16'h0099, "R4 txdata readback");
    repeat (12 * BT) @(negedge clk);
    bus_read(2, 16'h0060, "R5 ready after stop");
    tx_exp_q.push_back(8'hC5);
    bus_write(1, 16'h00C5);
    repeat (12 * BT) @(negedge clk);

    // R10 interrupt combining
    bus_write(3, 16'h0040);
    check(irq === 1'b1, "R10 trdy enabled", int'(irq), 1);
    bus_write(3, 16'h1000);
    check(irq === 1'b0, "R10 eop enable only", int'(irq), 0);
    bus_write(3, 16'h0000);

    // R6 receive
    send_rx(8'hA7, 1'b1);
    bus_read(2, 16'h00E0, "R6 receive ready");
    bus_read(0, 16'h00A7, "R6 rxdata");
    bus_read(2, 16'h0060, "R6 ready cleared");

    // R10 rx interrupt
    bus_write(3, 16'h0080);
    send_rx(8'h12, 1'b1);
    check(irq === 1'b1, "R10 rrdy irq", int'(irq), 1);
    bus_read(0, 16'h0012, "R6 rxdata 2");
    check(irq === 1'b0, "R10 irq drops after read", int'(irq), 0);
    bus_write(3, 16'h0000);

    // R7 overrun
    send_rx(8'h11, 1'b1);
    send_rx(8'h22, 1'b1);
    bus_read(2, 16'h01E8, "R7 overrun flags");
    bus_read(0, 16'h0011, "R7 first byte kept");
    bus_read(2, 16'h0060, "R9 overrun cleared");

    // R8 framing and break
    send_rx(8'h5A, 1'b0);
    bus_read(2, 16'h01E2, "R8 framing error");
    bus_read(0, 16'h005A, "R8 byte kept");
    send_rx(8'h00, 1'b0);
    bus_read(2, 16'h01E6, "R8 break");
    bus_read(0, 16'h0000, "R8 zero byte");
    bus_read(2, 16'h0060, "R9 clean after reads");

    // R11 forced break and control mask
    tx_mon_en = 1'b0;
    bus_write(3, 16'hFFFF);
    check(uart_txd === 1'b0, "R11 forced break", int'(uart_txd), 0);
    check(irq === 1'b1, "R10 all enabled", int'(irq), 1);
    bus_read(3, 16'h1FFF, "R11 control mask");
    bus_write(3, 16'h0000);
    check(uart_txd === 1'b1, "R11 break released", int'(uart_txd), 1);
    tx_mon_en = 1'b1;

    repeat (4) @(negedge clk);
    check(rd_exp_q.size() == 0, "R9 reads answered", rd_exp_q.size(), 0);
    check(tx_exp_q.size() == 0, "R5 frames sent", tx_exp_q.size(), 0);
    finish_run();
  end
endmodule